// File: doc/BRIEF.md
# Register-Controlled General-Purpose Pin Bank

This block drives and samples a bank of general-purpose pins from a simple 32-bit register bus. The bus has a select, a write strobe, a byte offset, write data and read data. Software can write the output value register and the direction register directly. Each of them also has two alias offsets: one that sets the bits where the write data is 1, and one that clears them. Several pins can therefore change in one bus write without a read-modify-write.

Each pin exports:
- an output value and an output enable;
- a pull-up enable and a pull-down enable;
- a 2-bit function select.

A pull-disable register turns pulls off per pin. When a pull is enabled on an input pin, the pin's output value bit picks its direction: 1 gives a pull-up and 0 a pull-down. Two function-select registers supply the low and high bit of each pin's function code. Incoming pin levels pass through a two-stage synchronizer before a read of the level register returns them.

Top module: `pin_bank`

## Requirements
- R1: After a synchronous active-low reset every register is zero. Every pin is then an input with its pull-down enabled, its pull-up disabled, its output value 0 and its function code 00.
- R2: A write to offset 0x00 loads the output value register from the write data. A read of offset 0x00 returns the synchronized pin levels, not the output value register.
- R3: A write to offset 0x04 sets each output value bit whose write data bit is 1. Bits written as 0 keep their value.
- R4: A write to offset 0x08 clears each output value bit whose write data bit is 1. Bits written as 0 keep their value.
- R5: The direction register drives the output enables, with 1 meaning output. Offset 0x10 writes it directly and reads it back. Offset 0x14 sets the bits written as 1, and offset 0x18 clears them.
- R6: Offset 0x0C holds the pull-disable register, which reads back. A 1 bit turns off both pulls on that pin. On an input pin with a 0 bit, the output value bit picks the pull: 1 enables the pull-up and 0 enables the pull-down. The two pulls are never enabled together.
- R7: On a pin whose direction bit is 1, both pull enables are 0.
- R8: Pin i's function code is {bit i of offset 0x24, bit i of offset 0x20}, and both registers read back.
- R9: A level change on a pin input first appears in a read of offset 0x00 after the second rising clock edge.
- R10: Offset 0x1C is read/write storage with no effect on any pin output. Offsets 0x04, 0x08, 0x14 and 0x18 read as zero. Unmapped offsets read as zero, and writes to them change nothing.
- R11: A bus cycle with the select low changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe (1 = write) |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data (combinational from offset) |
| pin_in | input | NPINS | Sampled pin levels |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin |
| pin_pu | output | NPINS | Pull-up enable per pin |
| pin_pd | output | NPINS | Pull-down enable per pin |
| pin_fsel | output | 2*NPINS | Function code, pin i at bits [2i+1:2i] |

## Verification
The bench builds the block with its default values, 32 pins and an 8-bit offset. At these values every register offset, including the unmapped 0x30, is reachable. The top pin, bit 31, can be driven through the direction and pull-disable paths. A vector table replays a sequence of direct, set and clear writes, and each step is checked against pad outputs worked out by hand. Directed tests then cover read-back, the function-code packing, deselected writes, the two-edge input latency and a mid-run reset.

// File: rtl/pin_bank_pkg.sv
// Package: byte offsets of the pin bank register map.
// Assumes an offset bus at least 6 bits wide.
package pin_bank_pkg;
    localparam int OFS_LEVEL = 'h00;   // write: output value, read: pin levels
    localparam int OFS_OSET  = 'h04;   // set output value bits
    localparam int OFS_OCLR  = 'h08;   // clear output value bits
    localparam int OFS_NOPUL = 'h0C;   // pull-disable
    localparam int OFS_DIR   = 'h10;   // direction (1 = output)
    localparam int OFS_DSET  = 'h14;   // set direction bits
    localparam int OFS_DCLR  = 'h18;   // clear direction bits
    localparam int OFS_SLEEP = 'h1C;   // plain storage
    localparam int OFS_FLO   = 'h20;   // function code low bit
    localparam int OFS_FHI   = 'h24;   // function code high bit
endpackage

// File: rtl/pin_bank_regs.sv
// Register file of the pin bank: decodes bus writes, including the
// set/clear aliases, into the control registers.
// Assumes the write data is exactly one bit per pin.
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  oval_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  nopull_q,
    output logic [NPINS-1:0]  sleep_q,
    output logic [NPINS-1:0]  flo_q,
    output logic [NPINS-1:0]  fhi_q
);
    logic hit_level, hit_oset, hit_oclr, hit_nopul;
    logic hit_dir, hit_dset, hit_dclr, hit_sleep, hit_flo, hit_fhi;

    // Decode which register the current write targets.
    always_comb begin
        hit_level = wr_en && (addr == ADDR_W'(OFS_LEVEL));
        hit_oset  = wr_en && (addr == ADDR_W'(OFS_OSET));
        hit_oclr  = wr_en && (addr == ADDR_W'(OFS_OCLR));
        hit_nopul = wr_en && (addr == ADDR_W'(OFS_NOPUL));
        hit_dir   = wr_en && (addr == ADDR_W'(OFS_DIR));
        hit_dset  = wr_en && (addr == ADDR_W'(OFS_DSET));
        hit_dclr  = wr_en && (addr == ADDR_W'(OFS_DCLR));
        hit_sleep = wr_en && (addr == ADDR_W'(OFS_SLEEP));
        hit_flo   = wr_en && (addr == ADDR_W'(OFS_FLO));
        hit_fhi   = wr_en && (addr == ADDR_W'(OFS_FHI));
    end

    // Output value register: direct load, atomic set or atomic clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         oval_q <= '0;
        else if (hit_level) oval_q <= wdata;
        else if (hit_oset)  oval_q <= oval_q | wdata;
        else if (hit_oclr)  oval_q <= oval_q & ~wdata;
    end

    // Direction register: direct load, atomic set or atomic clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '0;
        else if (hit_dir)  dir_q <= wdata;
        else if (hit_dset) dir_q <= dir_q | wdata;
        else if (hit_dclr) dir_q <= dir_q & ~wdata;
    end

    // Plain read/write registers: pull-disable, sleep storage, function bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nopull_q <= '0;
            sleep_q  <= '0;
            flo_q    <= '0;
            fhi_q    <= '0;
        end else begin
            if (hit_nopul) nopull_q <= wdata;
            if (hit_sleep) sleep_q  <= wdata;
            if (hit_flo)   flo_q    <= wdata;
            if (hit_fhi)   fhi_q    <= wdata;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (oval_q == '0 && dir_q == '0 && nopull_q == '0 && flo_q == '0 && fhi_q == '0));

    assert_set_keeps_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_OSET)) |=> (oval_q == ($past(oval_q) | $past(wdata))));

    assert_clear_keeps_zeros_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_OCLR)) |=> (oval_q == ($past(oval_q) & ~$past(wdata))));

    assert_idle_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(oval_q) && $stable(dir_q) && $stable(nopull_q)
                    && $stable(flo_q) && $stable(fhi_q)));
endmodule

// File: rtl/pin_bank_sync.sv
// Two-stage synchronizer for the incoming pin levels.
// Assumes each pin is an independent asynchronous level.
module pin_bank_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level_q
);
    logic [NPINS-1:0] meta_q;
    logic [1:0]       age_q;   // edges since reset, saturating at 2 (assertion aid)

    // Shift pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            level_q <= '0;
        end else begin
            meta_q  <= pin_in;
            level_q <= meta_q;
        end
    end

    // Count edges since reset so the latency check starts only once history exists.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_two_edge_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (level_q == $past(pin_in, 2)));
endmodule

// File: rtl/pin_bank_pads.sv
// Per-pin pad control: output enable, pull selection and function code.
// Assumes a direction bit of 1 means output and a pull-disable bit of 1 means no pull.
module pin_bank_pads #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]   oval,
    input  logic [NPINS-1:0]   dir,
    input  logic [NPINS-1:0]   nopull,
    input  logic [NPINS-1:0]   flo,
    input  logic [NPINS-1:0]   fhi,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [2*NPINS-1:0] pad_fsel
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic pull_on;

        // A pull acts only on an input pin that has pulls enabled.
        always_comb begin
            pull_on     = !dir[i] && !nopull[i];
            pad_out[i]  = oval[i];
            pad_oe[i]   = dir[i];
            pad_pu[i]   = pull_on && oval[i];
            pad_pd[i]   = pull_on && !oval[i];
            pad_fsel[2*i +: 2] = {fhi[i], flo[i]};
        end
    end
endmodule

// File: rtl/pin_bank.sv
// Top of the pin bank: register bus, register file, input synchronizer,
// pad control and read-back multiplexer.
// Assumes a bus data width equal to the pin count; reads are combinational.
module pin_bank
    import pin_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NPINS-1:0]    bus_wdata,
    output logic [NPINS-1:0]    bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [NPINS-1:0]    pin_pu,
    output logic [NPINS-1:0]    pin_pd,
    output logic [2*NPINS-1:0]  pin_fsel
);
    logic [NPINS-1:0] oval, dir, nopull, sleep, flo, fhi, level;
    logic             wr_en;

    // A write takes effect only on a selected write cycle.
    always_comb wr_en = bus_sel && bus_wr;

    pin_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .oval_q(oval), .dir_q(dir), .nopull_q(nopull), .sleep_q(sleep),
        .flo_q(flo), .fhi_q(fhi)
    );

    pin_bank_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .level_q(level)
    );

    pin_bank_pads #(.NPINS(NPINS)) u_pads (
        .oval(oval), .dir(dir), .nopull(nopull), .flo(flo), .fhi(fhi),
        .pad_out(pin_out), .pad_oe(pin_oe), .pad_pu(pin_pu), .pad_pd(pin_pd),
        .pad_fsel(pin_fsel)
    );

    // Read-back mux; aliases and unmapped offsets return zero.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_LEVEL): bus_rdata = level;
            ADDR_W'(OFS_NOPUL): bus_rdata = nopull;
            ADDR_W'(OFS_DIR):   bus_rdata = dir;
            ADDR_W'(OFS_SLEEP): bus_rdata = sleep;
            ADDR_W'(OFS_FLO):   bus_rdata = flo;
            ADDR_W'(OFS_FHI):   bus_rdata = fhi;
            default:            bus_rdata = '0;
        endcase
    end

    assert_no_pull_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & (pin_pu | pin_pd)) == '0);

    assert_pulls_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_pd) == '0);
endmodule

// File: tb/pin_bank_tb.sv
module pin_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int AW = 8;

    typedef struct packed {
        logic [7:0]    addr;
        logic [NP-1:0] wdata;
        logic [NP-1:0] e_out;
        logic [NP-1:0] e_oe;
        logic [NP-1:0] e_pu;
        logic [NP-1:0] e_pd;
        logic [7:0]    req;
    } vec_t;

    // Write sequence with expected pad outputs after each write.
    localparam vec_t VECS [10] = '{
        '{8'h00, 32'h0000_00F0, 32'h0000_00F0, 32'h0, 32'h0000_00F0, 32'hFFFF_FF0F, 8'd2},  // R2
        '{8'h04, 32'h0000_0F00, 32'h0000_0FF0, 32'h0, 32'h0000_0FF0, 32'hFFFF_F00F, 8'd3},  // R3
        '{8'h08, 32'h0000_0030, 32'h0000_0FC0, 32'h0, 32'h0000_0FC0, 32'hFFFF_F03F, 8'd4},  // R4
        '{8'h0C, 32'hFFFF_0000, 32'h0000_0FC0, 32'h0, 32'h0000_0FC0, 32'h0000_F03F, 8'd6},  // R6
        '{8'h14, 32'h0000_00FF, 32'h0000_0FC0, 32'h0000_00FF, 32'h0000_0F00, 32'h0000_F000, 8'd7}, // R7
        '{8'h18, 32'h0000_000F, 32'h0000_0FC0, 32'h0000_00F0, 32'h0000_0F00, 32'h0000_F00F, 8'd5}, // R5
        '{8'h10, 32'h8000_0000, 32'h0000_0FC0, 32'h8000_0000, 32'h0000_0FC0, 32'h0000_F03F, 8'd5}, // R5
        '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0FC0, 32'h8000_0000, 32'h0000_0FC0, 32'h0000_F03F, 8'd10},// R10
        '{8'h30, 32'hFFFF_FFFF, 32'h0000_0FC0, 32'h8000_0000, 32'h0000_0FC0, 32'h0000_F03F, 8'd10},// R10
        '{8'h04, 32'h0000_0000, 32'h0000_0FC0, 32'h8000_0000, 32'h0000_0FC0, 32'h0000_F03F, 8'd3}  // R3
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0, bus_rdata, pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_pu, pin_pd;
    logic [2*NP-1:0] pin_fsel;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_bank #(.NPINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .pin_pd(pin_pd), .pin_fsel(pin_fsel)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [NP-1:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [NP-1:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [NP-1:0] rd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 out", 64'(pin_out), 64'h0);
        check("R1 oe", 64'(pin_oe), 64'h0);
        check("R1 pu", 64'(pin_pu), 64'h0);
        check("R1 pd", 64'(pin_pd), 64'hFFFF_FFFF);
        check("R1 fsel", pin_fsel, 64'h0);

        for (int i = 0; i < 10; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata, 1'b1);
            check($sformatf("R%0d vec%0d out", VECS[i].req, i), 64'(pin_out), 64'(VECS[i].e_out));
            check($sformatf("R%0d vec%0d oe", VECS[i].req, i), 64'(pin_oe), 64'(VECS[i].e_oe));
            check($sformatf("R%0d vec%0d pu", VECS[i].req, i), 64'(pin_pu), 64'(VECS[i].e_pu));
            check($sformatf("R%0d vec%0d pd", VECS[i].req, i), 64'(pin_pd), 64'(VECS[i].e_pd));
        end

        // R6 / R5 / R10 read-back
        bus_read(8'h0C, rd); check("R6 readback", 64'(rd), 64'hFFFF_0000);
        bus_read(8'h10, rd); check("R5 readback", 64'(rd), 64'h8000_0000);
        bus_read(8'h1C, rd); check("R10 sleep readback", 64'(rd), 64'hFFFF_FFFF);
        bus_read(8'h04, rd); check("R10 oset reads 0", 64'(rd), 64'h0);
        bus_read(8'h08, rd); check("R10 oclr reads 0", 64'(rd), 64'h0);
        bus_read(8'h14, rd); check("R10 dset reads 0", 64'(rd), 64'h0);
        bus_read(8'h18, rd); check("R10 dclr reads 0", 64'(rd), 64'h0);
        bus_read(8'h30, rd); check("R10 unmapped reads 0", 64'(rd), 64'h0);
        // R2: level read returns pins (all 0), not output value 0xFC0
        bus_read(8'h00, rd); check("R2 level not latch", 64'(rd), 64'h0);

        // R8: function code packing
        bus_write(8'h20, 32'h5, 1'b1);
        bus_write(8'h24, 32'h6, 1'b1);
        check("R8 fsel", pin_fsel, 64'h39);
        bus_read(8'h20, rd); check("R8 low readback", 64'(rd), 64'h5);
        bus_read(8'h24, rd); check("R8 high readback", 64'(rd), 64'h6);

        // R11: deselected write is ignored
        bus_write(8'h00, 32'h0, 1'b0);
        check("R11 out unchanged", 64'(pin_out), 64'h0FC0);
        bus_write(8'h10, 32'h0, 1'b0);
        check("R11 oe unchanged", 64'(pin_oe), 64'h8000_0000);

        // R9: two-edge input latency
        @(negedge clk);
        pin_in = 32'hA5A5_A5A5;
        @(negedge clk);
        bus_read(8'h00, rd); check("R9 after one edge", 64'(rd), 64'h0);
        @(negedge clk);
        bus_read(8'h00, rd); check("R9 after two edges", 64'(rd), 64'hA5A5_A5A5);

        // R1: mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset oe", 64'(pin_oe), 64'h0);
        check("R1 re-reset pd", 64'(pin_pd), 64'hFFFF_FFFF);
        check("R1 re-reset fsel", pin_fsel, 64'h0);
        bus_read(8'h10, rd); check("R1 re-reset dir", 64'(rd), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule